// File: doc/BRIEF.md
# Two-Wire Clock-Synthesizer Programming Receiver

This block is the receiving side of a two-wire programming link, made of a serial clock line and a serial data line, that loads divider settings into a clock synthesizer. Both lines come in without a clock relationship to the chip. They pass through synchronizers into the fast system clock domain, where the block finds the edges of the serial clock.

Before any frame is taken, the host must send an unlock preamble. After that, a low start bit opens a frame of 24 data bits, sent least-significant bit first. Each bit uses a self-checking two-phase code: the host drives the inverse of the bit before the serial clock falls, then the true value before the clock rises. The block compares the two samples. A mismatch discards the frame and locks the link again.

A frame that ends with a valid high stop bit is committed. The three top bits of the word pick one of eight internal target registers, and the remaining 21 bits are written into that register. The decoded fields of the last accepted word are held on output ports, and a one-cycle strobe marks each commit. Protocol faults produce a one-cycle error pulse.

Top module: `clk_prog_rx`

## Requirements
- R1: During and after reset, word_valid and proto_err are 0, every field output is 0 and all eight target registers in bank_q read 0.
- R2: The link unlocks only on a serial-clock rise with data low that follows at least five consecutive serial-clock rises with data high. More than five high rises are also accepted.
- R3: A serial-clock rise with data low before five high rises have been counted clears the count, so two short runs of high rises do not add together.
- R4: The first rise after unlock is the start bit and must see data low. A high start bit pulses proto_err and locks the link again without committing anything.
- R5: Each data bit is the data level at a serial-clock rise. Bits are collected least-significant first, and exactly 24 of them make a word.
- R6: If the data level at the falling edge before a data bit's rise equals the level at that rise, proto_err pulses and the link locks again. Bits that follow are then ignored until a complete new preamble is sent.
- R7: The rise after bit 23 is the stop bit. With data high, the word is committed. With data low, proto_err pulses and nothing is written.
- R8: On commit, the field outputs take the word's fields and hold them until the next commit: f_sel = bits 23:21, f_idx = bits 20:17, f_n = bits 16:10, f_p = bits 9:7, f_d = bits 6:0.
- R9: On commit, target register k (where k = f_sel) takes word bits 20:0. It appears at bank_q[21k+20:21k]. All other target registers keep their values.
- R10: word_valid is high for exactly one system cycle per committed word, in the same cycle the new fields and register value first appear. It is never high together with proto_err.
- R11: After a commit or a fault, the preamble count restarts from zero. The stop-bit rise is not counted as a preamble rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_clk | input | 1 | Serial programming clock, asynchronous |
| prog_data | input | 1 | Serial programming data, asynchronous |
| word_valid | output | 1 | One-cycle strobe when a word is committed |
| proto_err | output | 1 | One-cycle pulse on a start, bit-code or stop fault |
| f_sel | output | 3 | Target-register select of the last accepted word |
| f_idx | output | 4 | Index field of the last accepted word |
| f_n | output | 7 | N divider field of the last accepted word |
| f_p | output | 3 | P field of the last accepted word |
| f_d | output | 7 | D divider field of the last accepted word |
| bank_q | output | 168 | Eight 21-bit target registers, register k at bits 21k+20:21k |

## Verification
Two functions share one serial-clock rise: the stop bit that commits a word, and the first rise of the next preamble, which also carries data high. The bench provokes this by sending an accepted word and then only four more high rises plus a low rise, with no fresh preamble. A following frame is then sent, and the bench judges the overlap correct only if that frame produces no word_valid and leaves the target registers unchanged. The same overlap is also exercised by three back-to-back loads that each carry a full preamble, all of which must commit.

// File: rtl/clk_prog_rx_pkg.sv
package clk_prog_rx_pkg;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/prog_line_sync.sv
module prog_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);

  logic [STAGES-1:0][LINES-1:0] chain_q;
  logic [STAGES-1:0][LINES-1:0] chain_d;

  assign chain_d[0] = line_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      assign chain_d[s] = chain_q[s-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign line_o = chain_q[STAGES-1];

endmodule

// File: rtl/prog_frame_rx.sv
module prog_frame_rx
  import clk_prog_rx_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int PRE_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ck_lvl,
  input  logic              dat_lvl,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(PRE_MIN + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(PRE_MIN);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  pre_q, pre_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              fall_q, fall_d;
  logic              ckp_q;
  logic              commit_q, commit_d;
  logic              err_q, err_d;
  logic              rise, fall;

  assign rise = ck_lvl & ~ckp_q;
  assign fall = ~ck_lvl & ckp_q;

  always_comb begin
    state_d  = state_q;
    pre_d    = pre_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    fall_d   = fall_q;
    commit_d = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_LOCK: begin
        if (rise) begin
          if (dat_lvl) begin
            if (pre_q != PRE_FULL) pre_d = pre_q + 1'b1;
          end else begin
            if (pre_q == PRE_FULL) state_d = ST_START;
            pre_d = '0;
          end
        end
      end
      ST_START: begin
        if (rise) begin
          if (!dat_lvl) begin
            state_d = ST_BITS;
            bit_d   = '0;
          end else begin
            err_d   = 1'b1;
            state_d = ST_LOCK;
          end
        end
      end
      ST_BITS: begin
        if (fall) fall_d = dat_lvl;
        if (rise) begin
          if (fall_q == dat_lvl) begin
            err_d   = 1'b1;
            state_d = ST_LOCK;
          end else begin
            sh_d = {dat_lvl, sh_q[WORD_W-1:1]};
            if (bit_q == BIT_LAST) state_d = ST_STOP;
            else                   bit_d   = bit_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (rise) begin
          if (dat_lvl) commit_d = 1'b1;
          else         err_d    = 1'b1;
          state_d = ST_LOCK;
        end
      end
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_LOCK;
      pre_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      fall_q   <= 1'b0;
      ckp_q    <= 1'b0;
      commit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      pre_q    <= pre_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      fall_q   <= fall_d;
      ckp_q    <= ck_lvl;
      commit_q <= commit_d;
      err_q    <= err_d;
    end
  end

  assign word_o   = sh_q;
  assign commit_o = commit_q;
  assign err_o    = err_q;

  // R5: a serial-clock rise cannot repeat on the next system cycle
  p_rise_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R10: commit strobe lasts a single cycle
  p_commit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R10: commit and fault never coincide
  p_commit_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_q && err_q));

  // R11: after commit the receiver is locked with a cleared count
  p_relock_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (state_q == ST_LOCK && pre_q == '0));

  // R6: any fault leaves the receiver locked
  p_relock_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> state_q == ST_LOCK);

  // R2: leaving the locked state needs a full preamble count
  p_unlock_needs_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && state_d == ST_START) |-> pre_q == PRE_FULL);

endmodule

// File: rtl/prog_reg_bank.sv
module prog_reg_bank #(
  parameter int SEL_W = 3,
  parameter int PAY_W = 21
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [PAY_W-1:0]                wr_data,
  output logic [(1<<SEL_W)*PAY_W-1:0]     bank_o
);

  localparam int NUM_REGS = 1 << SEL_W;

  logic [PAY_W-1:0] regs_q [NUM_REGS];
  logic [PAY_W-1:0] regs_d [NUM_REGS];

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(k));

      always_comb begin
        regs_d[k] = regs_q[k];
        if (hit) regs_d[k] = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[k] <= '0;
        else        regs_q[k] <= regs_d[k];
      end

      assign bank_o[k*PAY_W +: PAY_W] = regs_q[k];

      // R9: a register not addressed by a write keeps its value
      p_hold_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_W'(k)) |=> $stable(regs_q[k]));
    end
  endgenerate

endmodule

// File: rtl/clk_prog_rx.sv
module clk_prog_rx #(
  parameter int WORD_W  = 24,
  parameter int SEL_W   = 3,
  parameter int IDX_W   = 4,
  parameter int N_W     = 7,
  parameter int P_W     = 3,
  parameter int D_W     = 7,
  parameter int PRE_MIN = 5,
  parameter int SYNC_N  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   prog_clk,
  input  logic                                   prog_data,
  output logic                                   word_valid,
  output logic                                   proto_err,
  output logic [SEL_W-1:0]                       f_sel,
  output logic [IDX_W-1:0]                       f_idx,
  output logic [N_W-1:0]                         f_n,
  output logic [P_W-1:0]                         f_p,
  output logic [D_W-1:0]                         f_d,
  output logic [(1<<SEL_W)*(WORD_W-SEL_W)-1:0]   bank_q
);

  localparam int PAY_W = WORD_W - SEL_W;

  logic              rst_meta_q, rst_sync_q;
  logic [1:0]        lines_s;
  logic [WORD_W-1:0] word;
  logic              commit;
  logic              err;
  logic              valid_q;
  logic [WORD_W-1:0] fields_q, fields_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  prog_line_sync #(.LINES(2), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .line_i ({prog_data, prog_clk}),
    .line_o (lines_s)
  );

  prog_frame_rx #(.WORD_W(WORD_W), .PRE_MIN(PRE_MIN)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ck_lvl   (lines_s[0]),
    .dat_lvl  (lines_s[1]),
    .word_o   (word),
    .commit_o (commit),
    .err_o    (err)
  );

  prog_reg_bank #(.SEL_W(SEL_W), .PAY_W(PAY_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (commit),
    .wr_sel  (word[WORD_W-1 -: SEL_W]),
    .wr_data (word[PAY_W-1:0]),
    .bank_o  (bank_q)
  );

  always_comb begin
    fields_d = fields_q;
    if (commit) fields_d = word;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      fields_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      fields_q <= fields_d;
      valid_q  <= commit;
    end
  end

  assign word_valid = valid_q;
  assign proto_err  = err;
  assign f_sel      = fields_q[WORD_W-1 -: SEL_W];
  assign f_idx      = fields_q[PAY_W-1 -: IDX_W];
  assign f_n        = fields_q[D_W+P_W +: N_W];
  assign f_p        = fields_q[D_W +: P_W];
  assign f_d        = fields_q[0 +: D_W];

  // R8: held fields change only in a word_valid cycle
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !word_valid |-> $stable(fields_q));

endmodule

// File: tb/sim_clk_prog_rx.sv
`timescale 1ns/1ps
module sim_clk_prog_rx;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prog_clk;
  logic         prog_data;
  logic         word_valid;
  logic         proto_err;
  logic [2:0]   f_sel;
  logic [3:0]   f_idx;
  logic [6:0]   f_n;
  logic [2:0]   f_p;
  logic [6:0]   f_d;
  logic [167:0] bank_q;

  int vectors = 0;
  int miscompares = 0;
  int n_valid = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_prog_rx u0 (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_data(prog_data),
    .word_valid(word_valid), .proto_err(proto_err),
    .f_sel(f_sel), .f_idx(f_idx), .f_n(f_n), .f_p(f_p), .f_d(f_d),
    .bank_q(bank_q)
  );

  always @(posedge clk) begin
    if (word_valid) n_valid <= n_valid + 1;
    if (proto_err)  n_err   <= n_err + 1;
  end

  function automatic logic [20:0] reg_at(input int k);
    return bank_q[k*21 +: 21];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [167:0] act,
                     input logic [167:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv(input logic c, input logic d);
    prog_clk  = c;
    prog_data = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic unlock(input int highs);
    drv(0, 0);
    drv(0, 1);
    for (int i = 0; i < highs; i++) begin
      drv(1, 1);
      drv(0, 1);
    end
    drv(0, 0);
    drv(1, 0);
  endtask

  task automatic frame(input logic [23:0] w, input int bad, input logic stop_lvl);
    drv(0, 0);
    drv(1, 0);
    for (int i = 0; i < 24; i++) begin
      drv(1, ~w[i]);
      if (i == bad) drv(0, w[i]);
      else          drv(0, ~w[i]);
      drv(0, w[i]);
      drv(1, w[i]);
    end
    drv(1, 1);
    drv(0, 1);
    drv(1, stop_lvl);
    settle();
  endtask

  task automatic chk_fields(input logic [23:0] w, input string req);
    chk({f_sel, f_idx, f_n, f_p, f_d} == w, req, {f_sel, f_idx, f_n, f_p, f_d}, w);
  endtask

  localparam logic [23:0] W1 = {3'd2, 4'd9, 7'd100, 3'd5, 7'd33};
  localparam logic [23:0] W2 = {3'd5, 4'd3, 7'd7, 3'd2, 7'd120};
  localparam logic [23:0] WQ = 24'h492492;

  task automatic t_reset();
    chk(word_valid == 0 && proto_err == 0, "R1 strobes", {word_valid, proto_err}, 0);
    chk({f_sel, f_idx, f_n, f_p, f_d} == 0, "R1 fields", {f_sel, f_idx, f_n, f_p, f_d}, 0);
    chk(bank_q == 0, "R1 bank", bank_q, 0);
  endtask

  task automatic t_basic();
    int v0 = n_valid;
    int e0 = n_err;
    unlock(5);
    frame(W1, -1, 1);
    chk(n_valid - v0 == 1, "R2 R7 R10 one commit", n_valid - v0, 1);
    chk(n_err == e0, "R10 no error", n_err - e0, 0);
    chk_fields(W1, "R5 R8 fields");
    chk(reg_at(2) == W1[20:0], "R9 target reg 2", reg_at(2), W1[20:0]);
    chk(reg_at(5) == 0, "R9 other reg", reg_at(5), 0);
  endtask

  task automatic t_second_target();
    int v0 = n_valid;
    unlock(7);
    frame(W2, -1, 1);
    chk(n_valid - v0 == 1, "R2 long preamble accepted", n_valid - v0, 1);
    chk_fields(W2, "R8 fields second word");
    chk(reg_at(5) == W2[20:0], "R9 target reg 5", reg_at(5), W2[20:0]);
    chk(reg_at(2) == W1[20:0], "R9 reg 2 kept", reg_at(2), W1[20:0]);
  endtask

  task automatic t_short_preamble();
    int v0 = n_valid;
    logic [167:0] b0 = bank_q;
    unlock(4);
    frame(WQ, -1, 1);
    chk(n_valid == v0, "R2 four rises rejected", n_valid - v0, 0);
    chk(bank_q == b0, "R2 bank untouched", bank_q, b0);
  endtask

  task automatic t_split_preamble();
    int v0 = n_valid;
    logic [167:0] b0 = bank_q;
    drv(0, 0);
    drv(0, 1);
    for (int i = 0; i < 3; i++) begin drv(1, 1); drv(0, 1); end
    drv(0, 0);
    drv(1, 0);
    drv(0, 1);
    for (int i = 0; i < 3; i++) begin drv(1, 1); drv(0, 1); end
    drv(0, 0);
    drv(1, 0);
    frame(WQ, -1, 1);
    chk(n_valid == v0, "R3 split runs do not add", n_valid - v0, 0);
    chk(bank_q == b0, "R3 bank untouched", bank_q, b0);
  endtask

  task automatic t_start_high();
    int v0 = n_valid;
    int e0 = n_err;
    unlock(5);
    drv(0, 1);
    drv(1, 1);
    settle();
    chk(n_err - e0 == 1, "R4 high start flagged", n_err - e0, 1);
    chk(n_valid == v0, "R4 no commit", n_valid - v0, 0);
  endtask

  task automatic t_bad_code();
    int v0 = n_valid;
    int e0 = n_err;
    logic [167:0] b0 = bank_q;
    unlock(5);
    frame(WQ, 5, 1);
    chk(n_err - e0 == 1, "R6 code fault flagged", n_err - e0, 1);
    chk(n_valid == v0, "R6 no commit", n_valid - v0, 0);
    frame(W1, -1, 1);
    chk(n_valid == v0, "R6 fresh unlock required", n_valid - v0, 0);
    chk(bank_q == b0, "R6 bank untouched", bank_q, b0);
    chk_fields(W2, "R8 fields held after faults");
  endtask

  task automatic t_bad_stop();
    int v0 = n_valid;
    int e0 = n_err;
    logic [167:0] b0 = bank_q;
    unlock(5);
    frame(W1 ^ 24'h000111, -1, 0);
    chk(n_err - e0 == 1, "R7 low stop flagged", n_err - e0, 1);
    chk(n_valid == v0, "R7 no commit", n_valid - v0, 0);
    chk(bank_q == b0, "R7 bank untouched", bank_q, b0);
  endtask

  task automatic t_back_to_back();
    int v0 = n_valid;
    logic [23:0] w;
    for (int r = 0; r < 3; r++) begin
      w = {3'd7, 4'(r), 7'(10 + r), 3'(r), 7'(50 + r)};
      unlock(5);
      frame(w, -1, 1);
    end
    chk(n_valid - v0 == 3, "R10 R11 three loads", n_valid - v0, 3);
    chk(reg_at(7) == w[20:0], "R9 last load kept", reg_at(7), w[20:0]);
  endtask

  task automatic t_stop_not_counted();
    int v0;
    logic [167:0] b0;
    unlock(5);
    frame(W2, -1, 1);
    v0 = n_valid;
    b0 = bank_q;
    drv(0, 1);
    for (int i = 0; i < 4; i++) begin drv(1, 1); drv(0, 1); end
    drv(0, 0);
    drv(1, 0);
    frame(WQ, -1, 1);
    chk(n_valid == v0, "R11 stop rise not a preamble rise", n_valid - v0, 0);
    chk(bank_q == b0, "R11 bank untouched", bank_q, b0);
  endtask

  initial begin
    rst_n = 1'b0;
    prog_clk = 1'b0;
    prog_data = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_second_target();
    t_short_preamble();
    t_split_preamble();
    t_start_high();
    t_bad_code();
    t_bad_stop();
    t_back_to_back();
    t_stop_not_counted();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule